// File: doc/BRIEF.md
# Micro-op Dispatch Slot Allocator

This block is the in-order gate between instruction decode and the scheduler of an out-of-order core model. Each cycle it is offered up to `DISP_W` instructions, oldest in lane 0. Each one carries its micro-op count, a flag that it must open a dispatch group, a flag that it closes one, and a register-file readiness and a downstream readiness bit. A single count of free retire-buffer entries is shared by all lanes. The block decides through a combinational chain which lanes pass in this cycle and raises `in_ready` for them. It holds no instruction of its own, so a lane is accepted only if it leaves in the same cycle.

An instruction with more micro-ops than the dispatch width takes the whole cycle. The micro-ops that remain are carried into the cycles that follow. While they drain, the carried instruction uses slots before any new instruction gets them. One cycle after each decision, registered outputs report a dispatch event per accepted lane with its micro-op count, an event for the slots used by carried work, and the reason for the first refused lane.

Top module: `dsa_dispatch_gate`

## Requirements
- R1: While `rst` is high on a clock edge, the carry count clears and the registered event and stall outputs go to zero. In the first cycle after reset all `DISP_W` slots are free.
- R2: A lane is accepted only when the free slot count is at least min(U, `DISP_W`), where U is its micro-op count. An accepted lane with U <= `DISP_W` reduces the free count by U. A refusal for this reason reports stall code 1.
- R3: A lane with its begin-group flag set is accepted only when all `DISP_W` slots of the cycle are still free. Otherwise it is refused with stall code 2.
- R4: Once a lane with its end-group flag set is accepted, the free slot count is zero for the rest of that cycle.
- R5: An accepted lane with U > `DISP_W` uses every slot of the cycle and leaves a carry count of U - `DISP_W`.
- R6: At the start of a cycle with carry count C > 0, the free slots are `DISP_W` - C when C < `DISP_W` and zero otherwise. C drops by the slots the carried instruction uses. One cycle later a carry event reports that number on `carry_ev_uops`.
- R7: While the carry count is still nonzero after that start-of-cycle reduction, no lane is accepted. The refusal is reported with stall code 1.
- R8: The checks run in a fixed order, and the first one that fails sets the stall code: slots (1), begin-group (2), retire space (3), register file (4), downstream (5). The retire check fails when the full micro-op counts of the lanes accepted before this one, plus this lane's own count, exceed `rob_free`. Code 0 means no stall.
- R9: A lane is accepted only if every older lane is valid and accepted in the same cycle. A refused or idle lane blocks all younger lanes, and only the oldest refused lane sets the stall code.
- R10: One cycle after a lane is accepted, `ev_valid` for that lane is high and `ev_uops` gives min(U, `DISP_W`). It is low for lanes not accepted. The stall code of a cycle also appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | DISP_W | Lane holds an offered instruction, lane 0 oldest |
| in_uops | input | DISP_W*UOP_W | Micro-op count per lane |
| in_begin | input | DISP_W | Lane must open a dispatch group |
| in_end | input | DISP_W | Lane closes the dispatch group |
| in_rf_ok | input | DISP_W | Register file can take the lane's writes |
| in_ds_ok | input | DISP_W | Scheduler can take the lane this cycle |
| rob_free | input | ROB_W | Free retire-buffer entries this cycle |
| in_ready | output | DISP_W | Lane accepted this cycle (combinational) |
| ev_valid | output | DISP_W | Registered dispatch event per lane |
| ev_uops | output | DISP_W*UOP_W | Micro-ops reported per dispatch event |
| carry_ev_valid | output | 1 | Registered event for carried micro-ops |
| carry_ev_uops | output | UOP_W | Slots used by the carried instruction |
| stall_code | output | 3 | Registered reason of the oldest refused lane |

## Verification
A wrong carry count shows at the ports in the very next cycle. `in_ready` then admits or refuses the wrong lanes, and one cycle later `carry_ev_uops` reports the wrong slot usage. Slot-accounting faults inside the lane chain change `in_ready` in the same cycle. The bench catches them before the clock edge. A wrong order of checks leaves acceptance unchanged but shows as a wrong `stall_code` one cycle later. The bench therefore sets up inputs that fail more than one check at the same time.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef enum logic [2:0] {
    STALL_NONE       = 3'd0,
    STALL_SLOTS      = 3'd1,
    STALL_GROUP      = 3'd2,
    STALL_RETIRE     = 3'd3,
    STALL_REGFILE    = 3'd4,
    STALL_DOWNSTREAM = 3'd5
  } stall_e;

endpackage

// File: rtl/dsa_carry.sv
module dsa_carry #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [UOP_W-1:0] load_val,
  output logic [UOP_W-1:0] free_start,
  output logic             hold,
  output logic             cev_valid,
  output logic [UOP_W-1:0] cev_used
);

  localparam logic [UOP_W-1:0] FULL = UOP_W'(DISP_W);

  logic [UOP_W-1:0] carry_q;
  logic [UOP_W-1:0] carry_d;
  logic [UOP_W-1:0] rem;

  // start-of-cycle split of the carried micro-ops
  always_comb begin
    if (carry_q == '0) begin
      free_start = FULL;
      cev_used   = '0;
      rem        = '0;
    end else if (carry_q >= FULL) begin
      free_start = '0;
      cev_used   = FULL;
      rem        = carry_q - FULL;
    end else begin
      free_start = FULL - carry_q;
      cev_used   = carry_q;
      rem        = '0;
    end
    hold      = (rem != '0);
    cev_valid = (carry_q != '0);
    if (hold)      carry_d = rem;
    else if (load) carry_d = load_val;
    else           carry_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) carry_q <= '0;
    else     carry_q <= carry_d;
  end

  // R6: carried work strictly shrinks every cycle until it is gone
  a_r6_carry_shrinks: assert property (@(posedge clk) disable iff (rst)
    (carry_q != '0) |=> (carry_q < $past(carry_q)));

  // R7: no wide instruction may be taken while carried work remains
  a_r7_hold_no_load: assert property (@(posedge clk) disable iff (rst)
    hold |-> !load);

endmodule

// File: rtl/dsa_lane.sv
module dsa_lane import dsa_pkg::*; #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6
) (
  input  logic             en_in,
  input  logic             hold,
  input  logic             in_valid,
  input  logic [UOP_W-1:0] uops,
  input  logic             beg,
  input  logic             fin,
  input  logic             rf_ok,
  input  logic             ds_ok,
  input  logic [UOP_W-1:0] avail_in,
  input  logic [ROB_W-1:0] rob_used_in,
  input  logic [ROB_W-1:0] rob_free,
  output logic             accept,
  output logic             refuse,
  output stall_e           reason,
  output logic [UOP_W-1:0] avail_out,
  output logic [ROB_W-1:0] rob_used_out,
  output logic             wide,
  output logic [UOP_W-1:0] wide_rest,
  output logic [UOP_W-1:0] ev_uops
);

  localparam logic [UOP_W-1:0] FULL = UOP_W'(DISP_W);
  localparam int SUM_W = ((ROB_W > UOP_W) ? ROB_W : UOP_W) + 1;

  logic             over;
  logic [UOP_W-1:0] req;
  logic [SUM_W-1:0] rob_sum;
  logic             rob_fit;
  logic             live;
  stall_e           r;

  always_comb begin
    over    = (uops > FULL);
    req     = over ? FULL : uops;
    rob_sum = SUM_W'(rob_used_in) + SUM_W'(uops);
    rob_fit = (rob_sum <= SUM_W'(rob_free));

    // fixed check order: slots, group, retire, register file, downstream
    if (hold || (req > avail_in))      r = STALL_SLOTS;
    else if (beg && (avail_in != FULL)) r = STALL_GROUP;
    else if (!rob_fit)                  r = STALL_RETIRE;
    else if (!rf_ok)                    r = STALL_REGFILE;
    else if (!ds_ok)                    r = STALL_DOWNSTREAM;
    else                                r = STALL_NONE;

    live   = en_in && in_valid;
    accept = live && (r == STALL_NONE);
    refuse = live && (r != STALL_NONE);
    reason = refuse ? r : STALL_NONE;

    if (!accept)          avail_out = avail_in;
    else if (fin || over) avail_out = '0;
    else                  avail_out = avail_in - uops;

    rob_used_out = accept ? (rob_used_in + ROB_W'(uops)) : rob_used_in;
    wide         = accept && over;
    wide_rest    = uops - FULL;
    ev_uops      = req;
  end

endmodule

// File: rtl/dsa_event_reg.sv
module dsa_event_reg #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DISP_W-1:0]       acc,
  input  logic [DISP_W*UOP_W-1:0] evu,
  input  logic                    cev_v,
  input  logic [UOP_W-1:0]        cev_u,
  input  logic [2:0]              stall,
  output logic [DISP_W-1:0]       ev_valid_q,
  output logic [DISP_W*UOP_W-1:0] ev_uops_q,
  output logic                    cev_valid_q,
  output logic [UOP_W-1:0]        cev_uops_q,
  output logic [2:0]              stall_q
);

  localparam logic [UOP_W-1:0] FULL = UOP_W'(DISP_W);

  for (genvar g = 0; g < DISP_W; g++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst) begin
        ev_valid_q[g]                 <= 1'b0;
        ev_uops_q[g*UOP_W +: UOP_W]   <= '0;
      end else begin
        ev_valid_q[g]                 <= acc[g];
        ev_uops_q[g*UOP_W +: UOP_W]   <= acc[g] ? evu[g*UOP_W +: UOP_W] : '0;
      end
    end

    // R10: a reported event never exceeds the dispatch width
    a_r10_ev_bound: assert property (@(posedge clk) disable iff (rst)
      ev_valid_q[g] |-> (ev_uops_q[g*UOP_W +: UOP_W] <= FULL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cev_valid_q <= 1'b0;
      cev_uops_q  <= '0;
      stall_q     <= '0;
    end else begin
      cev_valid_q <= cev_v;
      cev_uops_q  <= cev_v ? cev_u : '0;
      stall_q     <= stall;
    end
  end

endmodule

// File: rtl/dsa_dispatch_gate.sv
module dsa_dispatch_gate import dsa_pkg::*; #(
  parameter int DISP_W = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DISP_W-1:0]       in_valid,
  input  logic [DISP_W*UOP_W-1:0] in_uops,
  input  logic [DISP_W-1:0]       in_begin,
  input  logic [DISP_W-1:0]       in_end,
  input  logic [DISP_W-1:0]       in_rf_ok,
  input  logic [DISP_W-1:0]       in_ds_ok,
  input  logic [ROB_W-1:0]        rob_free,
  output logic [DISP_W-1:0]       in_ready,
  output logic [DISP_W-1:0]       ev_valid,
  output logic [DISP_W*UOP_W-1:0] ev_uops,
  output logic                    carry_ev_valid,
  output logic [UOP_W-1:0]        carry_ev_uops,
  output logic [2:0]              stall_code
);

  localparam logic [UOP_W-1:0] FULL = UOP_W'(DISP_W);
  localparam int BUD_W = UOP_W + $clog2(DISP_W + 1) + 1;

  logic [UOP_W-1:0]        free_start;
  logic                    hold;
  logic                    cev_v;
  logic [UOP_W-1:0]        cev_u;
  logic                    load;
  logic [UOP_W-1:0]        load_val;

  logic [DISP_W:0]         en;
  logic [UOP_W-1:0]        avail   [DISP_W+1];
  logic [ROB_W-1:0]        rob_u   [DISP_W+1];
  logic [DISP_W-1:0]       refuse;
  stall_e                  reason  [DISP_W];
  logic [DISP_W-1:0]       wide;
  logic [UOP_W-1:0]        rest    [DISP_W];
  logic [DISP_W*UOP_W-1:0] evu;
  logic [2:0]              stall_or;
  logic [BUD_W-1:0]        budget;

  dsa_carry #(.DISP_W(DISP_W), .UOP_W(UOP_W)) u_carry (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (load_val),
    .free_start(free_start),
    .hold      (hold),
    .cev_valid (cev_v),
    .cev_used  (cev_u)
  );

  assign en[0]    = 1'b1;
  assign avail[0] = free_start;
  assign rob_u[0] = '0;

  for (genvar g = 0; g < DISP_W; g++) begin : g_lane
    dsa_lane #(.DISP_W(DISP_W), .UOP_W(UOP_W), .ROB_W(ROB_W)) u_lane (
      .en_in       (en[g]),
      .hold        (hold),
      .in_valid    (in_valid[g]),
      .uops        (in_uops[g*UOP_W +: UOP_W]),
      .beg         (in_begin[g]),
      .fin         (in_end[g]),
      .rf_ok       (in_rf_ok[g]),
      .ds_ok       (in_ds_ok[g]),
      .avail_in    (avail[g]),
      .rob_used_in (rob_u[g]),
      .rob_free    (rob_free),
      .accept      (in_ready[g]),
      .refuse      (refuse[g]),
      .reason      (reason[g]),
      .avail_out   (avail[g+1]),
      .rob_used_out(rob_u[g+1]),
      .wide        (wide[g]),
      .wide_rest   (rest[g]),
      .ev_uops     (evu[g*UOP_W +: UOP_W])
    );
    assign en[g+1] = in_ready[g];

    // R3: a begin-group lane only passes with the whole cycle still free
    a_r3_begin_full: assert property (@(posedge clk) disable iff (rst)
      (in_ready[g] && in_begin[g]) |-> (avail[g] == FULL));

    if (g > 0) begin : g_order
      // R9: a younger lane never passes ahead of an older one
      a_r9_in_order: assert property (@(posedge clk) disable iff (rst)
        in_ready[g] |-> in_ready[g-1]);
    end
  end

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    stall_or = '0;
    budget   = BUD_W'(cev_u);
    for (int i = 0; i < DISP_W; i++) begin
      load     = load | wide[i];
      load_val = load_val | (wide[i] ? rest[i] : '0);
      stall_or = stall_or | 3'(reason[i]);
      if (in_ready[i]) budget = budget + BUD_W'(evu[i*UOP_W +: UOP_W]);
    end
  end

  dsa_event_reg #(.DISP_W(DISP_W), .UOP_W(UOP_W)) u_events (
    .clk        (clk),
    .rst        (rst),
    .acc        (in_ready),
    .evu        (evu),
    .cev_v      (cev_v),
    .cev_u      (cev_u),
    .stall      (stall_or),
    .ev_valid_q (ev_valid),
    .ev_uops_q  (ev_uops),
    .cev_valid_q(carry_ev_valid),
    .cev_uops_q (carry_ev_uops),
    .stall_q    (stall_code)
  );

  // R2: carried and new micro-ops together never exceed the cycle's slots
  a_r2_budget: assert property (@(posedge clk) disable iff (rst)
    budget <= BUD_W'(DISP_W));

  // R7: carried work still pending blocks every lane
  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    hold |-> (in_ready == '0));

  // R8: at most one lane reports a refusal
  a_r8_one_refusal: assert property (@(posedge clk) disable iff (rst)
    $onehot0(refuse));

  // R10: events follow the acceptance pattern one cycle later
  a_r10_event_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ev_valid == $past(in_ready)));

endmodule

// File: tb/test_dsa_dispatch_gate.sv
module test_dsa_dispatch_gate;

  localparam int DISP_W = 4;
  localparam int UOP_W  = 4;
  localparam int ROB_W  = 6;
  localparam int CLK_PERIOD = 10;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic [DISP_W-1:0]       in_valid;
  logic [DISP_W*UOP_W-1:0] in_uops;
  logic [DISP_W-1:0]       in_begin;
  logic [DISP_W-1:0]       in_end;
  logic [DISP_W-1:0]       in_rf_ok;
  logic [DISP_W-1:0]       in_ds_ok;
  logic [ROB_W-1:0]        rob_free;
  logic [DISP_W-1:0]       in_ready;
  logic [DISP_W-1:0]       ev_valid;
  logic [DISP_W*UOP_W-1:0] ev_uops;
  logic                    carry_ev_valid;
  logic [UOP_W-1:0]        carry_ev_uops;
  logic [2:0]              stall_code;

  dsa_dispatch_gate #(.DISP_W(DISP_W), .UOP_W(UOP_W), .ROB_W(ROB_W)) i_dsa_dispatch_gate (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops),
    .in_begin(in_begin), .in_end(in_end), .in_rf_ok(in_rf_ok),
    .in_ds_ok(in_ds_ok), .rob_free(rob_free), .in_ready(in_ready),
    .ev_valid(ev_valid), .ev_uops(ev_uops), .carry_ev_valid(carry_ev_valid),
    .carry_ev_uops(carry_ev_uops), .stall_code(stall_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_err    = 0;

  bit bv [DISP_W];
  bit bb [DISP_W];
  bit be [DISP_W];
  bit brf[DISP_W];
  bit bds[DISP_W];
  int bu [DISP_W];
  int brob;
  int mc;

  bit m_acc[DISP_W];
  int m_evu[DISP_W];
  int m_reason;
  bit m_cev_v;
  int m_cev_u;
  int m_cnext;

  function automatic int min_w(int u);
    return (u > DISP_W) ? DISP_W : u;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference model of one cycle, built from the requirements
  task automatic model_eval();
    int c, free, robu, r;
    bit blocked, hold;
    c = mc;
    m_cev_v = 1'b0;
    m_cev_u = 0;
    if (c == 0) free = DISP_W;
    else begin
      free = (c >= DISP_W) ? 0 : DISP_W - c;
      m_cev_v = 1'b1;
      m_cev_u = DISP_W - free;
      c = c - m_cev_u;
    end
    hold = (c != 0);
    m_cnext = c;
    m_reason = 0;
    blocked = 1'b0;
    robu = 0;
    for (int i = 0; i < DISP_W; i++) begin
      m_acc[i] = 1'b0;
      m_evu[i] = 0;
      if (blocked) continue;
      if (!bv[i]) begin blocked = 1'b1; continue; end
      if (hold || min_w(bu[i]) > free) r = 1;
      else if (bb[i] && free != DISP_W) r = 2;
      else if (robu + bu[i] > brob) r = 3;
      else if (!brf[i]) r = 4;
      else if (!bds[i]) r = 5;
      else r = 0;
      if (r != 0) begin m_reason = r; blocked = 1'b1; continue; end
      m_acc[i] = 1'b1;
      m_evu[i] = min_w(bu[i]);
      robu += bu[i];
      if (bu[i] > DISP_W) begin free = 0; m_cnext = bu[i] - DISP_W; end
      else free -= bu[i];
      if (be[i]) free = 0;
    end
  endtask

  task automatic drive();
    for (int i = 0; i < DISP_W; i++) begin
      in_valid[i] = bv[i];
      in_uops[i*UOP_W +: UOP_W] = UOP_W'(bu[i]);
      in_begin[i] = bb[i];
      in_end[i]   = be[i];
      in_rf_ok[i] = brf[i];
      in_ds_ok[i] = bds[i];
    end
    rob_free = ROB_W'(brob);
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < DISP_W; i++) begin
      bv[i] = 0; bb[i] = 0; be[i] = 0; brf[i] = 1; bds[i] = 1; bu[i] = 1;
    end
    brob = 63;
  endtask

  task automatic set_lane(int i, int u, bit b, bit e);
    bv[i] = 1; bu[i] = u; bb[i] = b; be[i] = e;
  endtask

  // starts and ends on a falling edge
  task automatic step(string tag);
    drive();
    #1;
    model_eval();
    for (int i = 0; i < DISP_W; i++) chk(tag, "in_ready", int'(in_ready[i]), int'(m_acc[i]));
    @(posedge clk);
    mc = m_cnext;
    @(negedge clk);
    for (int i = 0; i < DISP_W; i++) begin
      chk(tag, "ev_valid", int'(ev_valid[i]), int'(m_acc[i]));
      if (m_acc[i]) chk(tag, "ev_uops", int'(ev_uops[i*UOP_W +: UOP_W]), m_evu[i]);
    end
    chk(tag, "carry_ev_valid", int'(carry_ev_valid), int'(m_cev_v));
    if (m_cev_v) chk(tag, "carry_ev_uops", int'(carry_ev_uops), m_cev_u);
    chk(tag, "stall_code", int'(stall_code), m_reason);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_lanes();
    drive();
    mc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ev_valid reset", int'(ev_valid), 0);
    chk("R1", "carry_ev_valid reset", int'(carry_ev_valid), 0);
    chk("R1", "stall_code reset", int'(stall_code), 0);
    rst = 1'b0;

    // R1: full width free after reset
    clear_lanes(); for (int i = 0; i < DISP_W; i++) set_lane(i, 1, 0, 0); step("R1");
    // R2: slot shortage
    clear_lanes(); set_lane(0, 2, 0, 0); set_lane(1, 2, 0, 0); set_lane(2, 1, 0, 0); step("R2");
    clear_lanes(); set_lane(0, 1, 0, 0); set_lane(1, 6, 0, 0); step("R2");
    clear_lanes(); set_lane(0, 1, 0, 0); set_lane(1, 3, 0, 0); set_lane(2, 1, 0, 0); step("R2");
    // R3: begin-group
    clear_lanes(); set_lane(0, 1, 0, 0); set_lane(1, 1, 1, 0); step("R3");
    clear_lanes(); set_lane(0, 2, 1, 0); set_lane(1, 2, 0, 0); step("R3");
    // R4: end-group
    clear_lanes(); set_lane(0, 1, 0, 1); set_lane(1, 1, 0, 0); step("R4");
    // R5 R6 R7: wide instruction with carry 7
    clear_lanes(); set_lane(0, 11, 0, 0); set_lane(1, 1, 0, 0); step("R5");
    clear_lanes(); set_lane(0, 1, 0, 0); step("R7");
    clear_lanes(); set_lane(0, 1, 0, 0); set_lane(1, 1, 0, 0); step("R6");
    clear_lanes(); for (int i = 0; i < DISP_W; i++) set_lane(i, 1, 0, 0); step("R6");
    // R6: carry exactly equal to the width
    clear_lanes(); set_lane(0, 8, 0, 0); step("R5");
    clear_lanes(); set_lane(0, 1, 0, 0); step("R6");
    clear_lanes(); set_lane(0, 1, 0, 0); step("R6");
    // R8: order of checks
    clear_lanes(); set_lane(0, 1, 0, 0); brob = 0; brf[0] = 0; step("R8");
    clear_lanes(); set_lane(0, 1, 0, 0); brf[0] = 0; bds[0] = 0; step("R8");
    clear_lanes(); set_lane(0, 1, 0, 0); bds[0] = 0; step("R8");
    clear_lanes(); set_lane(0, 3, 0, 0); set_lane(1, 2, 0, 0); brob = 4; brf[1] = 0; step("R8");
    clear_lanes(); set_lane(0, 11, 0, 0); brob = 8; step("R8");
    clear_lanes(); set_lane(0, 1, 0, 0); set_lane(1, 4, 1, 0); brob = 0; step("R8");
    // R9: refused lane blocks younger ones
    clear_lanes(); set_lane(0, 1, 0, 0); set_lane(1, 1, 0, 0); brf[0] = 0; step("R9");
    clear_lanes(); set_lane(1, 1, 0, 0); step("R9");
    // R10: event count clipped to the width
    clear_lanes(); set_lane(0, 9, 0, 0); step("R10");
    clear_lanes(); step("R10");
    clear_lanes(); step("R10");

    // random mix, checked against the model
    for (int n = 0; n < 400; n++) begin
      int nv;
      clear_lanes();
      nv = $urandom_range(0, DISP_W);
      for (int i = 0; i < nv; i++) begin
        set_lane(i, ($urandom % 6 == 0) ? $urandom_range(5, 12) : $urandom_range(1, 4),
                 ($urandom % 8 == 0), ($urandom % 8 == 0));
        brf[i] = ($urandom % 10 != 0);
        bds[i] = ($urandom % 10 != 0);
      end
      brob = $urandom_range(0, 40);
      step("R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule